// File: doc/BRIEF.md
# One-Bit SIMD Array Processing Element

This block is a single processing element of a large array that runs in lock step. Every element gets the same microinstruction from a host in the same clock. The element owns a 4096 x 1 bit data memory and a file of sixteen one-bit flags. The memory holds operands only and never holds program.

For each instruction the element fetches two memory bits and one flag. It looks up two result bits in eight-entry truth tables carried in the instruction word. It then stores one result in memory and one in a flag. A condition check can turn the instruction into a no-op: a chosen flag is compared with a sense bit. The memory result also leaves the element on a neighbour output, tagged with a direction code. A bit arriving from a neighbour is captured into the top flag. A debug port reads any memory bit combinationally.

An instruction takes three clock cycles: fetch A and the flags, fetch B, then evaluate and write back.

Top module: `bitpe_top`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `nbr_out` and `nbr_dir` are 0 and all sixteen flags read 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high for three cycles and `done` is high only in the third. The written results are visible one cycle after `done`.
- R3: A `start` pulse while `busy` is high is ignored. Neither the running instruction nor memory is affected by it.
- R4: The instruction word is the concatenation {ftab[7:0], mtab[7:0], news[1:0], sense, cflag[3:0], wflag[3:0], rflag[3:0], b_addr[11:0], a_addr[11:0]}, with a_addr in the low bits.
- R5: The lookup index is {mem[a_addr], mem[b_addr], flag[rflag]}, with the memory A bit as the MSB. On an executed instruction, mtab[index] is written to mem[a_addr].
- R6: On an executed instruction, ftab[index] is written to flag[wflag].
- R7: An instruction executes only when flag[cflag] equals `sense`. Otherwise memory and flags 0 to 14 are unchanged.
- R8: At the end of every instruction, whether it executed or not, `nbr_out` takes mtab[index] and `nbr_dir` takes the news field (0 north, 1 east, 2 west, 3 south). Both hold until the next instruction ends.
- R9: At the end of every instruction, flag 15 takes the value of `nbr_in`, whether the instruction executed or not. This capture takes priority over a flag write that addresses flag 15.
- R10: `dbg_data` shows mem[dbg_addr] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction strobe |
| instr | input | 55 | Broadcast microinstruction |
| nbr_in | input | 1 | Bit from the mesh neighbour |
| nbr_out | output | 1 | Memory result sent to the mesh |
| nbr_dir | output | 2 | Direction code for `nbr_out` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of an instruction |
| dbg_addr | input | 12 | Debug memory read address |
| dbg_data | output | 1 | Debug memory read data |

## Verification
Two things can land on flag 15 at the same clock edge: the neighbour capture and an executed flag write that addresses flag 15. The bench provokes this by issuing an instruction whose write-flag field is 15 and whose flag table yields 0, while `nbr_in` is 1. It judges the outcome by copying flag 15 into memory with a later instruction and reading it on the debug port; it must read 1. The same capture is also checked under a false condition, where it must still take place while every other write is suppressed.

// File: rtl/bitpe_pkg.sv
package bitpe_pkg;
  localparam int ADDR_W  = 12;
  localparam int FLAG_AW = 4;
  localparam int NFLAGS  = 1 << FLAG_AW;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int LUT_N   = 8;
  localparam int DIR_W   = 2;
  localparam int NBR_FLAG = NFLAGS - 1;
  localparam int INSTR_W = 2*LUT_N + DIR_W + 1 + 3*FLAG_AW + 2*ADDR_W;

  typedef struct packed {
    logic [LUT_N-1:0]   ftab;
    logic [LUT_N-1:0]   mtab;
    logic [DIR_W-1:0]   news;
    logic               sense;
    logic [FLAG_AW-1:0] cflag;
    logic [FLAG_AW-1:0] wflag;
    logic [FLAG_AW-1:0] rflag;
    logic [ADDR_W-1:0]  b_addr;
    logic [ADDR_W-1:0]  a_addr;
  } pe_instr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FA, ST_FB, ST_EX} pe_state_e;
endpackage

// File: rtl/bitpe_ctrl.sv
module bitpe_ctrl
  import bitpe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic ph_a,
  output logic ph_b,
  output logic ph_x,
  output logic busy
);
  pe_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_FA;
      ST_FA:   st_d = ST_FB;
      ST_FB:   st_d = ST_EX;
      ST_EX:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign load_en = (st_q == ST_IDLE) && start;
  assign ph_a    = (st_q == ST_FA);
  assign ph_b    = (st_q == ST_FB);
  assign ph_x    = (st_q == ST_EX);
  assign busy    = (st_q != ST_IDLE);
endmodule

// File: rtl/bitpe_mem.sv
module bitpe_mem
  import bitpe_pkg::*;
(
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic              dbg_data,
  output logic [DEPTH-1:0]  mem_vec
);
  logic [DEPTH-1:0] store_q;

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
  end

  assign rd_data  = store_q[rd_addr];
  assign dbg_data = store_q[dbg_addr];
  assign mem_vec  = store_q;
endmodule

// File: rtl/bitpe_flags.sv
module bitpe_flags
  import bitpe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLAG_AW-1:0] rd_addr,
  output logic               rd_data,
  input  logic [FLAG_AW-1:0] cond_addr,
  output logic               cond_data,
  input  logic               wr_en,
  input  logic [FLAG_AW-1:0] wr_addr,
  input  logic               wr_data,
  input  logic               cap_en,
  input  logic               cap_data,
  output logic [NFLAGS-1:0]  flag_vec
);
  logic [NFLAGS-1:0] fl_q, fl_d;

  always_comb begin
    fl_d = fl_q;
    if (wr_en)  fl_d[wr_addr]  = wr_data;
    if (cap_en) fl_d[NBR_FLAG] = cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign rd_data   = fl_q[rd_addr];
  assign cond_data = fl_q[cond_addr];
  assign flag_vec  = fl_q;
endmodule

// File: rtl/bitpe_top.sv
module bitpe_top
  import bitpe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic               nbr_in,
  output logic               nbr_out,
  output logic [DIR_W-1:0]   nbr_dir,
  output logic               busy,
  output logic               done,
  input  logic [ADDR_W-1:0]  dbg_addr,
  output logic               dbg_data
);
  pe_instr_t         ins_q, ins_d;
  logic              load_en, ph_a, ph_b, ph_x;
  logic              a_q, b_q, f_q, ok_q;
  logic              a_d, b_d, f_d, ok_d;
  logic              rd_bit, rf_bit, cf_bit;
  logic [2:0]        lut_idx;
  logic              mem_res, flag_res, exec;
  logic              nout_q, nout_d;
  logic [DIR_W-1:0]  ndir_q, ndir_d;
  logic [ADDR_W-1:0] rd_addr;
  logic [DEPTH-1:0]  mem_vec;
  logic [NFLAGS-1:0] flag_vec;

  bitpe_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .load_en(load_en),
    .ph_a(ph_a), .ph_b(ph_b), .ph_x(ph_x), .busy(busy)
  );

  assign rd_addr = ph_a ? ins_q.a_addr : ins_q.b_addr;

  bitpe_mem u_mem (
    .clk(clk), .rd_addr(rd_addr), .rd_data(rd_bit),
    .wr_en(exec), .wr_addr(ins_q.a_addr), .wr_data(mem_res),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .mem_vec(mem_vec)
  );

  bitpe_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(ins_q.rflag), .rd_data(rf_bit),
    .cond_addr(ins_q.cflag), .cond_data(cf_bit),
    .wr_en(exec), .wr_addr(ins_q.wflag), .wr_data(flag_res),
    .cap_en(ph_x), .cap_data(nbr_in), .flag_vec(flag_vec)
  );

  // operand and instruction capture
  always_comb begin
    ins_d  = ins_q;
    a_d    = a_q;
    b_d    = b_q;
    f_d    = f_q;
    ok_d   = ok_q;
    nout_d = nout_q;
    ndir_d = ndir_q;
    if (load_en) ins_d = pe_instr_t'(instr);
    if (ph_a) begin
      a_d  = rd_bit;
      f_d  = rf_bit;
      ok_d = (cf_bit == ins_q.sense);
    end
    if (ph_b) b_d = rd_bit;
    if (ph_x) begin
      nout_d = mem_res;
      ndir_d = ins_q.news;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= '0;
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      f_q    <= 1'b0;
      ok_q   <= 1'b0;
      nout_q <= 1'b0;
      ndir_q <= '0;
    end else begin
      ins_q  <= ins_d;
      a_q    <= a_d;
      b_q    <= b_d;
      f_q    <= f_d;
      ok_q   <= ok_d;
      nout_q <= nout_d;
      ndir_q <= ndir_d;
    end
  end

  assign lut_idx  = {a_q, b_q, f_q};
  assign mem_res  = ins_q.mtab[lut_idx];
  assign flag_res = ins_q.ftab[lut_idx];
  assign exec     = ph_x && ok_q;
  assign done     = ph_x;
  assign nbr_out  = nout_q;
  assign nbr_dir  = ndir_q;
endmodule

// File: rtl/bitpe_chk.sv
module bitpe_chk
  import bitpe_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              exec,
  input logic              nbr_in,
  input logic              nbr_out,
  input logic [DEPTH-1:0]  mem_vec,
  input logic [NFLAGS-1:0] flag_vec
);
  // R2
  start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R2
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R7
  gated_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(mem_vec));
  // R9
  nbr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (flag_vec[NBR_FLAG] == $past(nbr_in)));
  // R8
  nbr_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(nbr_out));
  // R1
  reset_flags_chk: assert property (@(posedge clk)
    !rst_n |-> (flag_vec == '0));
endmodule

bind bitpe_top bitpe_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .exec(exec), .nbr_in(nbr_in), .nbr_out(nbr_out),
  .mem_vec(mem_vec), .flag_vec(flag_vec)
);

// File: tb/bitpe_top_tb_top.sv
module bitpe_top_tb_top;
  import bitpe_pkg::*;

  logic               clk;
  logic               rst_n;
  logic               start;
  logic [INSTR_W-1:0] instr;
  logic               nbr_in;
  logic               nbr_out;
  logic [DIR_W-1:0]   nbr_dir;
  logic               busy;
  logic               done;
  logic [ADDR_W-1:0]  dbg_addr;
  logic               dbg_data;
  int total = 0;
  int bad   = 0;
  bit finished = 0;

  bitpe_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .nbr_in(nbr_in), .nbr_out(nbr_out), .nbr_dir(nbr_dir),
    .busy(busy), .done(done), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 layout
  function automatic logic [INSTR_W-1:0] mk(
    input logic [11:0] a, input logic [11:0] b, input logic [3:0] rf,
    input logic [3:0] wf, input logic [3:0] cf, input logic sn,
    input logic [7:0] mt, input logic [7:0] ft, input logic [1:0] nw);
    return {ft, mt, nw, sn, cf, wf, rf, b, a};
  endfunction

  // issue one instruction and wait until results are visible
  task automatic run(input logic [INSTR_W-1:0] w);
    @(negedge clk); start = 1; instr = w;
    @(negedge clk); start = 0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [INSTR_W-1:0] setm(input logic [11:0] a, input logic v);
    return mk(a, 12'd0, 4'd0, 4'd14, 4'd0, 1'b0, v ? 8'hFF : 8'h00, 8'h00, 2'd0);
  endfunction

  task automatic rd(input logic [11:0] a, output logic v);
    dbg_addr = a; #1; v = dbg_data;
  endtask

  // read a flag by copying it into memory address 12'hFFF
  task automatic rdflag(input logic [3:0] f, output logic v);
    run(mk(12'hFFF, 12'd0, f, 4'd14, 4'd0, 1'b0, 8'hAA, 8'h00, 2'd0));
    rd(12'hFFF, v);
  endtask

  task automatic t_reset;
    logic v;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 nbr_out", nbr_out, 0);
    chk("R1 nbr_dir", nbr_dir, 0);
    rdflag(4'd3, v);
    chk("R1 flag3", v, 0);
    rdflag(4'd9, v);
    chk("R1 flag9", v, 0);
  endtask

  task automatic t_timing;
    logic v;
    @(negedge clk); start = 1; instr = setm(12'd5, 1'b1);
    @(negedge clk); start = 0;
    chk("R2 busy c1", busy, 1); chk("R2 done c1", done, 0);
    @(negedge clk);
    chk("R2 busy c2", busy, 1); chk("R2 done c2", done, 0);
    @(negedge clk);
    chk("R2 busy c3", busy, 1); chk("R2 done c3", done, 1);
    @(negedge clk);
    chk("R2 busy end", busy, 0); chk("R2 done end", done, 0);
    rd(12'd5, v);
    chk("R2 written", v, 1);
  endtask

  task automatic t_const_dbg;
    logic v;
    run(setm(12'd6, 1'b0));
    run(setm(12'd7, 1'b1));
    rd(12'd6, v); chk("R10 addr6", v, 0);
    rd(12'd7, v); chk("R10 addr7", v, 1);
    rd(12'd5, v); chk("R10 addr5", v, 1);
  endtask

  // R5: xor of A and B written to A
  task automatic t_alu_mem;
    logic v;
    for (int k = 0; k < 4; k++) begin
      run(setm(12'd100 + 12'(k), k[1]));
      run(setm(12'd200 + 12'(k), k[0]));
      run(mk(12'd100 + 12'(k), 12'd200 + 12'(k), 4'd2, 4'd14, 4'd0, 1'b0,
             8'h3C, 8'h00, 2'd0));
      rd(12'd100 + 12'(k), v);
      chk("R5 xor", v, k[1] ^ k[0]);
    end
    // A as MSB: table 0xF0 returns A
    run(setm(12'd300, 1'b1));
    run(setm(12'd301, 1'b0));
    run(mk(12'd301, 12'd300, 4'd2, 4'd14, 4'd0, 1'b0, 8'hF0, 8'h00, 2'd0));
    rd(12'd301, v);
    chk("R5 msb", v, 0);
  endtask

  // R6: flag3 = A and B
  task automatic t_flag_write;
    logic v;
    run(setm(12'd400, 1'b1));
    run(setm(12'd401, 1'b1));
    run(mk(12'd400, 12'd401, 4'd0, 4'd3, 4'd0, 1'b0, 8'hF0, 8'hC0, 2'd0));
    rdflag(4'd3, v);
    chk("R6 flag3", v, 1);
    rd(12'd400, v);
    chk("R6 mem kept", v, 1);
  endtask

  // R7: flag3 is 1
  task automatic t_cond;
    logic v;
    run(mk(12'd6, 12'd0, 4'd0, 4'd4, 4'd3, 1'b0, 8'hFF, 8'hFF, 2'd0));
    rd(12'd6, v); chk("R7 no mem write", v, 0);
    rdflag(4'd4, v); chk("R7 no flag write", v, 0);
    run(mk(12'd6, 12'd0, 4'd0, 4'd4, 4'd3, 1'b1, 8'hFF, 8'hFF, 2'd0));
    rd(12'd6, v); chk("R7 mem write", v, 1);
    rdflag(4'd4, v); chk("R7 flag write", v, 1);
  endtask

  // R8 and R9
  task automatic t_nbr;
    logic v;
    nbr_in = 1;
    run(mk(12'd7, 12'd0, 4'd0, 4'd5, 4'd3, 1'b0, 8'h00, 8'hFF, 2'd2));
    nbr_in = 0;
    chk("R8 nbr_out", nbr_out, 0);
    chk("R8 nbr_dir", nbr_dir, 2);
    rd(12'd7, v); chk("R9 gated mem", v, 1);
    rdflag(4'd15, v); chk("R9 capture gated", v, 1);
    run(mk(12'd8, 12'd0, 4'd0, 4'd14, 4'd3, 1'b0, 8'hFF, 8'h00, 2'd3));
    chk("R8 nbr_out gated", nbr_out, 1);
    chk("R8 nbr_dir south", nbr_dir, 3);
    // collision: write 0 to flag 15 while neighbour brings 1
    nbr_in = 1;
    run(mk(12'd9, 12'd0, 4'd0, 4'd15, 4'd0, 1'b0, 8'h00, 8'h00, 2'd1));
    nbr_in = 0;
    chk("R8 nbr_dir east", nbr_dir, 1);
    rdflag(4'd15, v); chk("R9 priority", v, 1);
  endtask

  // R3
  task automatic t_busy_start;
    logic v;
    run(setm(12'd500, 1'b0));
    run(setm(12'd501, 1'b0));
    @(negedge clk); start = 1; instr = setm(12'd500, 1'b1);
    @(negedge clk); instr = setm(12'd501, 1'b1);
    @(negedge clk); start = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 idle after", busy, 0);
    rd(12'd500, v); chk("R3 first done", v, 1);
    rd(12'd501, v); chk("R3 ignored", v, 0);
  endtask

  initial begin
    rst_n = 0; start = 0; instr = '0; nbr_in = 0; dbg_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_const_dbg();
    t_alu_mem();
    t_flag_write();
    t_cond();
    t_nbr();
    t_busy_start();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule